// File: doc/BRIEF.md
# Configuration Access Decoder

This block turns host I/O cycles into configuration transactions. A 32-bit address register, loaded through one I/O port, selects a bus, device, function and register. A data port then opens a window onto that location. Each access to the data window is routed to one of four places. It may go to the local register file of an on-chip device on bus 0. It may complete locally as a reserved location. It may become a configuration cycle on the downstream bus, either type 0 with a one-hot device select or type 1 with the address passed through unchanged. Otherwise it is handed back to the I/O path as an ordinary cycle.

Requests arrive as single-cycle strobes with a dword-aligned port address, byte enables and write data. Every result appears on the registered outputs exactly one clock after its request. The downstream bus range comes from two inputs holding the secondary and subordinate bus numbers. The bench sets these before any request. The secondary bus is never 0.

Top module: `cfg_access_decoder`

## Requirements
- R1: While rst_ni is low and after its release, the address register reads 0 and every output is 0 until a request arrives.
- R2: A write to port 0x0CF8 with all four byte enables set loads the full 32-bit address register. A read of that port with all four byte enables set returns the register on rd_data_o with rd_valid_o high.
- R3: An access to port 0x0CF8 with any other byte-enable pattern leaves the address register unchanged and raises io_pass_o.
- R4: An access to port 0x0CFC raises io_pass_o and starts no configuration cycle in three cases: bit 31 of the address register (enable) is 0, no byte is enabled, or the access targets any other port.
- R5: The address fields are bus [23:16], device [15:11], function [10:8] and register [7:2]. With enable set, a data-window access to bus 0 with function 0 and device 0, 1, 3 or 6 raises int_req_o with the device, function, register, byte enables, direction and write data. A read returns int_rdata_i on rd_data_o in that same cycle.
- R6: A data-window access to bus 0, device 0, 1, 3 or 6 with a nonzero function is reserved. A read completes with rd_valid_o high and rd_data_o 0. A write produces no output at all.
- R7: A data-window access to bus 0 with any other device number raises io_pass_o.
- R8: When the bus equals sec_bus_i, dn_req_o rises with dn_type1_o 0. dn_addr_o has bit 16+device set for devices 0 to 15, bits 15:11 zero, the function in 10:8, the register in 7:2 and bits 1:0 equal to 00.
- R9: A type 0 cycle to a device number of 16 or more drives dn_addr_o[31:16] all zero. The function and register fields keep their normal positions.
- R10: When the bus is above sec_bus_i and no higher than sub_bus_i, dn_req_o rises with dn_type1_o 1. dn_addr_o[31:24] is 0, bits 23:2 are copied from the address register, and bits 1:0 equal 01.
- R11: A data-window access to a nonzero bus outside the secondary-to-subordinate range raises io_pass_o.
- R12: Each request produces its result exactly one cycle later and nothing at any other time. At most one of io_pass_o, int_req_o and dn_req_o is high in any cycle. cyc_we_o, cyc_be_o and cyc_wdata_o are 0 except alongside int_req_o or dn_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_req_i | input | 1 | Single-cycle I/O request strobe |
| io_we_i | input | 1 | 1 for write, 0 for read |
| io_addr_i | input | 16 | Dword-aligned I/O port address |
| io_be_i | input | 4 | Byte enables |
| io_wdata_i | input | 32 | Write data |
| sec_bus_i | input | 8 | Secondary bus number |
| sub_bus_i | input | 8 | Subordinate bus number |
| int_rdata_i | input | 32 | Read data returned by the internal register file |
| io_pass_o | output | 1 | Request handed back as an ordinary I/O cycle |
| int_req_o | output | 1 | Internal register access strobe |
| int_dev_o | output | 5 | Internal device number |
| int_fn_o | output | 3 | Internal function number |
| int_reg_o | output | 6 | Internal dword register index |
| dn_req_o | output | 1 | Downstream configuration cycle strobe |
| dn_type1_o | output | 1 | 1 for type 1, 0 for type 0 |
| dn_addr_o | output | 32 | Downstream configuration address |
| cyc_we_o | output | 1 | Direction of the internal or downstream cycle |
| cyc_be_o | output | 4 | Byte enables of the internal or downstream cycle |
| cyc_wdata_o | output | 32 | Write data of the internal or downstream cycle |
| rd_valid_o | output | 1 | Locally completed read data valid |
| rd_data_o | output | 32 | Locally completed read data |

## Verification
Some rules are checked by assertions on every cycle. These are: the single-target rule, silence when nothing was requested, the one-hot and zero fields of a type 0 address, the low bits and bus range of a type 1 address, that internal strobes only name function 0 of an on-chip device, and that the address register moves only on a full-dword write to its port. Other behaviour needs the bench's reference model and scenarios. This covers the route chosen for each bus and device, the exact addresses, reserved reads returning zero, and reserved writes leaving no trace. It also covers byte-wide writes to the address port leaving the register intact, and readback of the address register.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 6;
  localparam int IDSEL_W = 1 << (DEV_W - 1);

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PASS,
    TGT_ADDR_RD,
    TGT_INT,
    TGT_RSV,
    TGT_TYPE0,
    TGT_TYPE1
  } tgt_e;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/cfg_idsel.sv
module cfg_idsel import cfg_dec_pkg::*; (
  input  logic [DEV_W-1:0]   dev_i,
  output logic [IDSEL_W-1:0] idsel_o
);
  // devices with the top bit set match no line
  for (genvar i = 0; i < IDSEL_W; i++) begin : g_line
    assign idsel_o[i] = (dev_i == DEV_W'(i));
  end
endmodule

// File: rtl/cfg_route.sv
module cfg_route import cfg_dec_pkg::*; #(
  parameter int                PORT_W       = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT    = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_PORT    = 16'h0CFC,
  parameter logic [31:0]       INT_DEV_MASK = 32'h0000_004B
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [3:0]        be_i,
  input  logic              en_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic [BUS_W-1:0]  sec_i,
  input  logic [BUS_W-1:0]  sub_i,
  output tgt_e              tgt_o,
  output logic              addr_wr_o
);
  always_comb begin
    tgt_o     = TGT_NONE;
    addr_wr_o = 1'b0;
    if (req_i) begin
      if (port_i == ADDR_PORT) begin
        if (be_i == 4'hF) begin
          if (we_i) addr_wr_o = 1'b1;
          else      tgt_o     = TGT_ADDR_RD;
        end else begin
          tgt_o = TGT_PASS;
        end
      end else if (port_i == DATA_PORT && en_i && be_i != 4'h0) begin
        if (bus_i == '0) begin
          if (INT_DEV_MASK[dev_i]) tgt_o = (fn_i == '0) ? TGT_INT : TGT_RSV;
          else                     tgt_o = TGT_PASS;
        end else if (bus_i == sec_i) begin
          tgt_o = TGT_TYPE0;
        end else if (bus_i > sec_i && bus_i <= sub_i) begin
          tgt_o = TGT_TYPE1;
        end else begin
          tgt_o = TGT_PASS;
        end
      end else begin
        tgt_o = TGT_PASS;
      end
    end
  end
endmodule

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder import cfg_dec_pkg::*; #(
  parameter int                PORT_W       = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT    = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_PORT    = 16'h0CFC,
  parameter logic [31:0]       INT_DEV_MASK = 32'h0000_004B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_req_i,
  input  logic              io_we_i,
  input  logic [PORT_W-1:0] io_addr_i,
  input  logic [3:0]        io_be_i,
  input  logic [31:0]       io_wdata_i,
  input  logic [BUS_W-1:0]  sec_bus_i,
  input  logic [BUS_W-1:0]  sub_bus_i,
  input  logic [31:0]       int_rdata_i,
  output logic              io_pass_o,
  output logic              int_req_o,
  output logic [DEV_W-1:0]  int_dev_o,
  output logic [FN_W-1:0]   int_fn_o,
  output logic [REG_W-1:0]  int_reg_o,
  output logic              dn_req_o,
  output logic              dn_type1_o,
  output logic [31:0]       dn_addr_o,
  output logic              cyc_we_o,
  output logic [3:0]        cyc_be_o,
  output logic [31:0]       cyc_wdata_o,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o
);
  logic [31:0]        addr_q;
  logic               addr_wr;
  tgt_e               tgt;
  logic [IDSEL_W-1:0] idsel;
  logic               rd_int_q;
  logic [31:0]        rd_hold_q;

  wire               cfg_en  = addr_q[31];
  wire [BUS_W-1:0]   cfg_bus = addr_q[23:16];
  wire [DEV_W-1:0]   cfg_dev = addr_q[15:11];
  wire [FN_W-1:0]    cfg_fn  = addr_q[10:8];
  wire [REG_W-1:0]   cfg_reg = addr_q[7:2];

  cfg_addr_reg u_addr (
    .clk_i, .rst_ni, .wr_i(addr_wr), .wdata_i(io_wdata_i), .q_o(addr_q)
  );

  cfg_route #(
    .PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT),
    .INT_DEV_MASK(INT_DEV_MASK)
  ) u_route (
    .req_i(io_req_i), .we_i(io_we_i), .port_i(io_addr_i), .be_i(io_be_i),
    .en_i(cfg_en), .bus_i(cfg_bus), .dev_i(cfg_dev), .fn_i(cfg_fn),
    .sec_i(sec_bus_i), .sub_i(sub_bus_i), .tgt_o(tgt), .addr_wr_o(addr_wr)
  );

  cfg_idsel u_idsel (.dev_i(cfg_dev), .idsel_o(idsel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_pass_o   <= 1'b0;
      int_req_o   <= 1'b0;
      int_dev_o   <= '0;
      int_fn_o    <= '0;
      int_reg_o   <= '0;
      dn_req_o    <= 1'b0;
      dn_type1_o  <= 1'b0;
      dn_addr_o   <= '0;
      cyc_we_o    <= 1'b0;
      cyc_be_o    <= '0;
      cyc_wdata_o <= '0;
      rd_valid_o  <= 1'b0;
      rd_int_q    <= 1'b0;
      rd_hold_q   <= '0;
    end else begin
      io_pass_o   <= 1'b0;
      int_req_o   <= 1'b0;
      int_dev_o   <= '0;
      int_fn_o    <= '0;
      int_reg_o   <= '0;
      dn_req_o    <= 1'b0;
      dn_type1_o  <= 1'b0;
      dn_addr_o   <= '0;
      cyc_we_o    <= 1'b0;
      cyc_be_o    <= '0;
      cyc_wdata_o <= '0;
      rd_valid_o  <= 1'b0;
      rd_int_q    <= 1'b0;
      rd_hold_q   <= '0;
      if (tgt == TGT_INT || tgt == TGT_TYPE0 || tgt == TGT_TYPE1) begin
        cyc_we_o    <= io_we_i;
        cyc_be_o    <= io_be_i;
        cyc_wdata_o <= io_wdata_i;
      end
      unique case (tgt)
        TGT_PASS:    io_pass_o <= 1'b1;
        TGT_ADDR_RD: begin
          rd_valid_o <= 1'b1;
          rd_hold_q  <= addr_q;
        end
        TGT_INT: begin
          int_req_o  <= 1'b1;
          int_dev_o  <= cfg_dev;
          int_fn_o   <= cfg_fn;
          int_reg_o  <= cfg_reg;
          rd_valid_o <= !io_we_i;
          rd_int_q   <= !io_we_i;
        end
        TGT_RSV:     rd_valid_o <= !io_we_i;  // zero data, writes dropped
        TGT_TYPE0: begin
          dn_req_o  <= 1'b1;
          dn_addr_o <= {idsel, {DEV_W{1'b0}}, cfg_fn, cfg_reg, 2'b00};
        end
        TGT_TYPE1: begin
          dn_req_o   <= 1'b1;
          dn_type1_o <= 1'b1;
          dn_addr_o  <= {8'h00, addr_q[23:2], 2'b01};
        end
        default: ;
      endcase
    end
  end

  assign rd_data_o = rd_int_q ? int_rdata_i : rd_hold_q;

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_pass_o, int_req_o, dn_req_o})); // R12
  AST_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_req_i |=> !(io_pass_o || int_req_o || dn_req_o || rd_valid_o)); // R12
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_req_i && io_we_i && io_addr_i == ADDR_PORT && io_be_i == 4'hF)
      |=> $stable(addr_q)); // R3
  AST_INT_FN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o |-> (int_fn_o == '0 && INT_DEV_MASK[int_dev_o])); // R5
  AST_TYPE0_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_o && !dn_type1_o) |->
      ($onehot0(dn_addr_o[31:16]) && dn_addr_o[15:11] == '0 && dn_addr_o[1:0] == 2'b00)); // R8
  AST_TYPE1_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_o && dn_type1_o) |->
      (dn_addr_o[1:0] == 2'b01 && dn_addr_o[31:24] == '0 &&
       dn_addr_o[23:16] > sec_bus_i && dn_addr_o[23:16] <= sub_bus_i)); // R10
endmodule

// File: tb/cfg_access_decoder_test.sv
module cfg_access_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req = 0, we = 0;
  logic [15:0] port = 0;
  logic [3:0]  be = 0;
  logic [31:0] wd = 0;
  logic [7:0]  sec = 8'd1, sub = 8'd4;
  logic [31:0] irdata = 32'h5EED_C0DE;

  logic        pass_o, ireq_o, dreq_o, t1_o, cwe_o, rv_o;
  logic [4:0]  idev_o;
  logic [2:0]  ifn_o;
  logic [5:0]  ireg_o;
  logic [31:0] daddr_o, cwd_o, rd_o;
  logic [3:0]  cbe_o;

  cfg_access_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .io_req_i(req), .io_we_i(we), .io_addr_i(port),
    .io_be_i(be), .io_wdata_i(wd), .sec_bus_i(sec), .sub_bus_i(sub),
    .int_rdata_i(irdata), .io_pass_o(pass_o), .int_req_o(ireq_o),
    .int_dev_o(idev_o), .int_fn_o(ifn_o), .int_reg_o(ireg_o), .dn_req_o(dreq_o),
    .dn_type1_o(t1_o), .dn_addr_o(daddr_o), .cyc_we_o(cwe_o), .cyc_be_o(cbe_o),
    .cyc_wdata_o(cwd_o), .rd_valid_o(rv_o), .rd_data_o(rd_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_addr;
  logic        e_pass, e_int, e_dn, e_t1, e_rv, e_we;
  logic [4:0]  e_dev;
  logic [2:0]  e_fn;
  logic [5:0]  e_reg;
  logic [31:0] e_daddr, e_rd, e_wd;
  logic [3:0]  e_be;
  string       e_tag;
  int          m_bus, m_dev, m_fn, m_reg;

  task automatic clr();
    e_pass = 0; e_int = 0; e_dn = 0; e_t1 = 0; e_rv = 0; e_we = 0;
    e_dev = 0; e_fn = 0; e_reg = 0; e_daddr = 0; e_rd = 0; e_wd = 0; e_be = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; clr(); e_tag = "R1";
    end else begin
      clr();
      e_tag = "R12";
      if (req) begin
        m_bus = int'(m_addr[23:16]); m_dev = int'(m_addr[15:11]);
        m_fn = int'(m_addr[10:8]); m_reg = int'(m_addr[7:2]);
        if (port == 16'h0CF8) begin
          if (be == 4'hF) begin
            e_tag = "R2";
            if (we) m_addr = wd;
            else begin e_rv = 1; e_rd = m_addr; end
          end else begin
            e_tag = "R3"; e_pass = 1;
          end
        end else if (port == 16'h0CFC && m_addr[31] && be != 0) begin
          if (m_bus == 0) begin
            if (m_dev == 0 || m_dev == 1 || m_dev == 3 || m_dev == 6) begin
              if (m_fn == 0) begin
                e_tag = "R5"; e_int = 1; e_dev = 5'(m_dev); e_fn = 0; e_reg = 6'(m_reg);
                e_we = we; e_be = be; e_wd = wd;
                if (!we) begin e_rv = 1; e_rd = irdata; end
              end else begin
                e_tag = "R6";
                if (!we) begin e_rv = 1; e_rd = 0; end
              end
            end else begin
              e_tag = "R7"; e_pass = 1;
            end
          end else if (m_bus == int'(sec)) begin
            e_tag = (m_dev < 16) ? "R8" : "R9";
            e_dn = 1; e_we = we; e_be = be; e_wd = wd;
            e_daddr = (32'(m_fn) << 8) | (32'(m_reg) << 2);
            if (m_dev < 16) e_daddr = e_daddr | (32'd1 << (16 + m_dev));
          end else if (m_bus > int'(sec) && m_bus <= int'(sub)) begin
            e_tag = "R10"; e_dn = 1; e_t1 = 1; e_we = we; e_be = be; e_wd = wd;
            e_daddr = {8'h00, m_addr[23:2], 2'b01};
          end else begin
            e_tag = "R11"; e_pass = 1;
          end
        end else begin
          e_tag = "R4"; e_pass = 1;
        end
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(e_tag, "pass/int/dn/rv", {28'd0, pass_o, ireq_o, dreq_o, rv_o},
          {28'd0, e_pass, e_int, e_dn, e_rv});
      chk(e_tag, "cyc we/be", {27'd0, cwe_o, cbe_o}, {27'd0, e_we, e_be});
      chk(e_tag, "cyc wdata", cwd_o, e_wd);
      if (e_int)
        chk(e_tag, "int dev/fn/reg", {18'd0, idev_o, ifn_o, ireg_o}, {18'd0, e_dev, e_fn, e_reg});
      if (e_dn) begin
        chk(e_tag, "dn type1", {31'd0, t1_o}, {31'd0, e_t1});
        chk(e_tag, "dn addr", daddr_o, e_daddr);
      end
      if (e_rv) chk(e_tag, "rd data", rd_o, e_rd);
    end
  end

  function automatic logic [31:0] ca(bit en, int bus, int dev, int fn, int rg);
    return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
  endfunction

  task automatic io(bit w, logic [15:0] p, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; port = p; be = b; wd = d;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req = 0; we = 0; port = 0; be = 0; wd = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic cfg_rd(bit en, int bus, int dev, int fn, int rg);
    io(1, 16'h0CF8, 4'hF, ca(en, bus, dev, fn, rg));
    io(0, 16'h0CFC, 4'hF, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle while in reset
    chk("R1", "outputs in reset", {28'd0, pass_o, ireq_o, dreq_o, rv_o}, 32'd0);
    chk("R1", "dn addr in reset", daddr_o, 32'd0);
    rst_n = 1;
    idle(2);
    io(0, 16'h0CF8, 4'hF, 0);                         // R1 reset value readback
    idle(2);
    // R2 load and readback
    io(1, 16'h0CF8, 4'hF, 32'h8000_0004);
    io(0, 16'h0CF8, 4'hF, 0);
    // R5 internal device hits
    io(0, 16'h0CFC, 4'hF, 0);
    io(1, 16'h0CFC, 4'h3, 32'hDEAD_BEEF);
    cfg_rd(1, 0, 1, 0, 6'h3F);
    cfg_rd(1, 0, 6, 0, 2);
    io(1, 16'h0CFC, 4'h8, 32'h1234_5678);
    // R6 reserved functions
    cfg_rd(1, 0, 3, 1, 5);
    io(1, 16'h0CFC, 4'hF, 32'hFFFF_FFFF);
    idle(1);
    cfg_rd(1, 0, 6, 7, 9);
    // R7 bus 0 non-internal devices
    cfg_rd(1, 0, 2, 0, 0);
    cfg_rd(1, 0, 31, 0, 0);
    // R8 type 0
    cfg_rd(1, 1, 5, 2, 6'h11);
    cfg_rd(1, 1, 0, 0, 0);
    cfg_rd(1, 1, 15, 7, 6'h3F);
    io(1, 16'h0CFC, 4'h6, 32'h0BAD_F00D);
    // R9 type 0 with high device numbers
    cfg_rd(1, 1, 16, 3, 1);
    cfg_rd(1, 1, 31, 1, 2);
    // R10 type 1 inside the range, edges included
    cfg_rd(1, 2, 7, 1, 4);
    cfg_rd(1, 4, 31, 7, 6'h3F);
    io(1, 16'h0CFC, 4'h1, 32'h0000_00AA);
    // R11 outside the range
    cfg_rd(1, 5, 0, 0, 0);
    cfg_rd(1, 8'h80, 3, 0, 0);
    // R4 enable clear, empty byte enables, other ports
    cfg_rd(0, 1, 2, 0, 0);
    cfg_rd(0, 0, 0, 0, 0);
    io(1, 16'h0CF8, 4'hF, ca(1, 1, 2, 0, 0));
    io(0, 16'h0CFC, 4'h0, 0);
    io(1, 16'h0080, 4'hF, 32'h55);
    io(0, 16'h0CF4, 4'hF, 0);
    idle(1);
    // R3 partial access to the address port, then readback
    io(1, 16'h0CF8, 4'hF, 32'h8001_2804);
    io(1, 16'h0CF8, 4'h1, 32'h0000_00FF);
    io(1, 16'h0CF8, 4'hC, 32'hFFFF_0000);
    io(0, 16'h0CF8, 4'h3, 0);
    io(0, 16'h0CF8, 4'hF, 0);
    io(0, 16'h0CFC, 4'hF, 0);
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule